// File: doc/BRIEF.md
# Rectangle Blitter for Byte-Pixel Video Memory

This engine moves a rectangle of 8-bit pixels inside video memory. Each row is walked left to right and the rows top to bottom. For every pixel the engine reads a source byte and the destination byte, combines them with a raster operation and writes the result back to the destination address. Bases, pitches, extent, mode flags, the raster-operation code and two expansion colours live in a small register file. A control write launches the walk.

The source can be used in three ways. In the first it is read as plain bytes. In the second it is a monochrome bitmap, where each bit selects one of two colour registers. In the third it is an 8x8 tile that repeats across the rectangle. The tile can also be combined with the monochrome expansion. The engine works on a single-port memory with one cycle of read latency, and every address wraps at the top of the memory.

Top module: `rect_blitter`

## Requirements
- R1: The extent registers are inclusive. A width value W and a height value H write (W+1)*(H+1) pixels, each destination address exactly once, in row-major order.
- R2: The destination of pixel x in row r is dst_base + r*dst_pitch + x.
- R3: With no mode flags set, the source of pixel x in row r is src_base + r*src_pitch + x, and the source byte is used unchanged.
- R4: With mode bit 7 set (expand), the byte at src_base + r*src_pitch + floor(x/8) supplies bit 7-(x mod 8). A 1 selects the foreground colour and a 0 selects the background colour.
- R5: With mode bit 6 set (tile), the source of pixel x in row r is src_base + 8*(r mod 8) + (x mod 8). When bit 7 is also set, the source is src_base + 8*(r mod 8) and bit 7-(x mod 8) selects the colour.
- R6: Every source and destination address wraps modulo 2^ADDR_W.
- R7: Raster code 0x00 writes 0x00, code 0x0B writes the inverted destination, code 0x0D writes the source pixel, and every other code also writes the source pixel.
- R8: Each pixel takes 4 cycles: a source read, a destination read, a write, and an advance step. The write follows a read directly, so busy lasts 4*(W+1)*(H+1) cycles.
- R9: Register selectors are 0 source base, 1 destination base, 2 source pitch, 3 destination pitch, 4 width, 5 height, 6 mode, 7 raster code, 8 foreground, 9 background, and 10 control. A control write with bit 1 set starts a walk only while idle and only when mode bit 2 is clear. Any other control write has no effect. While idle, the memory port is quiet.
- R10: done pulses for exactly one cycle, in the first cycle that busy is low after a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register selector |
| reg_wdata | input | ADDR_W | Register write data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |

## Verification
The bench builds the engine with ADDR_W=10 and DIM_W=8. The 1 KiB space lets a few short rows cross the top of memory. A pitch near 1024 then acts as a negative step, which exercises the wrap on both the row step and the within-row offset. Heights of 9 rows and widths up to 16 are small enough for quick runs. They still cover tile row 8 folding back to tile row 0 and expanded rows that cross more than one source byte.

// File: rtl/blit_pkg.sv
package blit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SRC,
    ST_RD_DST,
    ST_WRITE,
    ST_NEXT
  } blit_state_e;

  localparam logic [7:0] ROP_ZERO    = 8'h00;
  localparam logic [7:0] ROP_NOT_DST = 8'h0B;
  localparam logic [7:0] ROP_SRC     = 8'h0D;

  localparam logic [3:0] SEL_SRC_BASE  = 4'd0;
  localparam logic [3:0] SEL_DST_BASE  = 4'd1;
  localparam logic [3:0] SEL_SRC_PITCH = 4'd2;
  localparam logic [3:0] SEL_DST_PITCH = 4'd3;
  localparam logic [3:0] SEL_WIDTH     = 4'd4;
  localparam logic [3:0] SEL_HEIGHT    = 4'd5;
  localparam logic [3:0] SEL_MODE      = 4'd6;
  localparam logic [3:0] SEL_ROP       = 4'd7;
  localparam logic [3:0] SEL_FG        = 4'd8;
  localparam logic [3:0] SEL_BG        = 4'd9;
  localparam logic [3:0] SEL_CTRL      = 4'd10;

  localparam int MODE_EXPAND_BIT  = 7;
  localparam int MODE_TILE_BIT    = 6;
  localparam int MODE_HOST_BIT    = 2;
  localparam int CTRL_START_BIT   = 1;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              busy,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [ADDR_W-1:0] src_pitch,
  output logic [ADDR_W-1:0] dst_pitch,
  output logic [DIM_W-1:0]  width,
  output logic [DIM_W-1:0]  height,
  output logic              mode_expand,
  output logic              mode_tile,
  output logic [7:0]        rop,
  output logic [7:0]        fg,
  output logic [7:0]        bg,
  output logic              start
);
  logic mode_host;

  function automatic logic hit(input logic [3:0] s);
    return reg_we && (reg_sel == s);
  endfunction

  always_comb begin
    start = hit(SEL_CTRL) && reg_wdata[CTRL_START_BIT] && !mode_host && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base    <= '0;
      dst_base    <= '0;
      src_pitch   <= '0;
      dst_pitch   <= '0;
      width       <= '0;
      height      <= '0;
      mode_expand <= 1'b0;
      mode_tile   <= 1'b0;
      mode_host   <= 1'b0;
      rop         <= '0;
      fg          <= '0;
      bg          <= '0;
    end else begin
      if (hit(SEL_SRC_BASE))  src_base  <= reg_wdata;
      if (hit(SEL_DST_BASE))  dst_base  <= reg_wdata;
      if (hit(SEL_SRC_PITCH)) src_pitch <= reg_wdata;
      if (hit(SEL_DST_PITCH)) dst_pitch <= reg_wdata;
      if (hit(SEL_WIDTH))     width     <= reg_wdata[DIM_W-1:0];
      if (hit(SEL_HEIGHT))    height    <= reg_wdata[DIM_W-1:0];
      if (hit(SEL_MODE)) begin
        mode_expand <= reg_wdata[MODE_EXPAND_BIT];
        mode_tile   <= reg_wdata[MODE_TILE_BIT];
        mode_host   <= reg_wdata[MODE_HOST_BIT];
      end
      if (hit(SEL_ROP)) rop <= reg_wdata[7:0];
      if (hit(SEL_FG))  fg  <= reg_wdata[7:0];
      if (hit(SEL_BG))  bg  <= reg_wdata[7:0];
    end
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int ADDR_W = 12,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [ADDR_W-1:0] src_pitch,
  input  logic [ADDR_W-1:0] dst_pitch,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic              mode_expand,
  input  logic              mode_tile,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [2:0]        bit_idx,
  output logic              last
);
  logic [DIM_W-1:0]  x_q, x_d, y_q, y_d;
  logic [ADDR_W-1:0] srow_q, srow_d, drow_q, drow_d;
  logic              row_end;

  always_comb begin
    row_end = (x_q == width);
    last    = row_end && (y_q == height);
    x_d     = x_q;
    y_d     = y_q;
    srow_d  = srow_q;
    drow_d  = drow_q;
    if (load) begin
      x_d    = '0;
      y_d    = '0;
      srow_d = src_base;
      drow_d = dst_base;
    end else if (step) begin
      if (row_end) begin
        x_d    = '0;
        y_d    = y_q + DIM_W'(1);
        srow_d = srow_q + src_pitch;
        drow_d = drow_q + dst_pitch;
      end else begin
        x_d = x_q + DIM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      srow_q <= '0;
      drow_q <= '0;
    end else begin
      x_q    <= x_d;
      y_q    <= y_d;
      srow_q <= srow_d;
      drow_q <= drow_d;
    end
  end

  always_comb begin
    bit_idx  = 3'd7 - x_q[2:0];
    dst_addr = drow_q + ADDR_W'(x_q);
    if (mode_tile) begin
      src_addr = src_base + ADDR_W'({y_q[2:0], 3'b000})
               + (mode_expand ? '0 : ADDR_W'(x_q[2:0]));
    end else begin
      src_addr = srow_q + (mode_expand ? ADDR_W'(x_q >> 3) : ADDR_W'(x_q));
    end
  end
endmodule

// File: rtl/blit_rop.sv
module blit_rop
  import blit_pkg::*;
(
  input  logic [7:0] rop,
  input  logic [7:0] src_pix,
  input  logic [7:0] dst_pix,
  output logic [7:0] result
);
  always_comb begin
    unique case (rop)
      ROP_ZERO:    result = 8'h00;
      ROP_NOT_DST: result = ~dst_pix;
      ROP_SRC:     result = src_pix;
      default:     result = src_pix;
    endcase
  end
endmodule

// File: rtl/rect_blitter.sv
module rect_blitter
  import blit_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic              busy,
  output logic              done,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic              rst_m, rst_s;
  blit_state_e       state_q, state_d;
  logic [ADDR_W-1:0] src_base, dst_base, src_pitch, dst_pitch;
  logic [DIM_W-1:0]  width, height;
  logic              mode_expand, mode_tile, start;
  logic [7:0]        rop_code, fg, bg;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [2:0]        bit_idx;
  logic              last;
  logic [7:0]        src_byte_q, src_pix;
  logic              done_d, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  blit_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy),
    .src_base(src_base), .dst_base(dst_base),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch),
    .width(width), .height(height),
    .mode_expand(mode_expand), .mode_tile(mode_tile),
    .rop(rop_code), .fg(fg), .bg(bg), .start(start)
  );

  blit_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_walk (
    .clk(clk), .rst_n(rst_s), .load(start), .step(state_q == ST_NEXT),
    .src_base(src_base), .dst_base(dst_base),
    .src_pitch(src_pitch), .dst_pitch(dst_pitch),
    .width(width), .height(height),
    .mode_expand(mode_expand), .mode_tile(mode_tile),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .bit_idx(bit_idx), .last(last)
  );

  always_comb begin
    if (mode_expand) src_pix = src_byte_q[bit_idx] ? fg : bg;
    else             src_pix = src_byte_q;
  end

  blit_rop u_rop (
    .rop(rop_code), .src_pix(src_pix), .dst_pix(mem_rdata), .result(mem_wdata)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_RD_SRC;
      ST_RD_SRC: state_d = ST_RD_DST;
      ST_RD_DST: state_d = ST_WRITE;
      ST_WRITE:  state_d = ST_NEXT;
      ST_NEXT: begin
        if (last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_RD_SRC;
        end
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q    <= ST_IDLE;
      done_q     <= 1'b0;
      src_byte_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (state_q == ST_RD_DST) src_byte_q <= mem_rdata;
    end
  end

  always_comb begin
    busy     = (state_q != ST_IDLE);
    done     = done_q;
    mem_rd   = (state_q == ST_RD_SRC) || (state_q == ST_RD_DST);
    mem_wr   = (state_q == ST_WRITE);
    mem_addr = (state_q == ST_RD_SRC) ? src_addr : dst_addr;
  end
endmodule

// File: rtl/blit_checker.sv
module blit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [7:0] mem_wdata,
  input logic [7:0] rop
);
  a_r8_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  a_r8_advance_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (!mem_wr && !mem_rd));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));
  a_r7_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && rop == 8'h00) |-> (mem_wdata == 8'h00));
endmodule

bind rect_blitter blit_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .rop(rop_code)
);

// File: tb/test_rect_blitter.sv
module test_rect_blitter;
  localparam int AW   = 10;
  localparam int DW   = 8;
  localparam int MSZ  = 1 << AW;
  localparam int MASK = MSZ - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [3:0]    reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic          busy, done, mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata;

  always #2 clk = ~clk;

  rect_blitter #(.ADDR_W(AW), .DIM_W(DW)) i_rect_blitter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .busy(busy), .done(done),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] vmem [MSZ];
  int         shadow [MSZ];
  int         expq [$];
  int         checks = 0, errors = 0, events = 0;
  int         busy_cycles = 0, done_seen = 0, cycles = 0;
  logic       prev_busy = 1'b0;
  string      cur_req = "R9";

  always @(posedge clk) begin
    if (mem_wr) vmem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= vmem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference: compare each memory transaction with the next expected one.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd || mem_wr) begin
        int got;
        got = ((mem_wr ? 2 : 1) << 20) | (int'(mem_addr) << 8)
            | (mem_wr ? int'(mem_wdata) : 0);
        events++;
        if (expq.size() == 0) chk(1'b0, cur_req, "unexpected access", got, 0);
        else begin
          int e;
          e = expq.pop_front();
          chk(got == e, cur_req, "access kind/addr/data", got, e);
        end
      end
      if (busy) busy_cycles++;
      if (done) done_seen++;
      if (prev_busy && !busy) chk(done == 1'b1, "R10", "done at busy fall", done, 1);
      prev_busy <= busy;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] s, input int d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_sel = s;
    reg_wdata = AW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic model(input int sb, db, sp, dp, w, h, md, rop, fg, bg);
    bit ex, tl;
    ex = md[7];
    tl = md[6];
    for (int r = 0; r <= h; r++) begin
      for (int x = 0; x <= w; x++) begin
        int sa, da, sv, pix, dv, res;
        if (tl) sa = (sb + 8 * (r % 8) + (ex ? 0 : x % 8)) & MASK;
        else    sa = (sb + r * sp + (ex ? x / 8 : x)) & MASK;
        da = (db + r * dp + x) & MASK;
        expq.push_back((1 << 20) | (sa << 8));
        expq.push_back((1 << 20) | (da << 8));
        sv = shadow[sa];
        if (ex) pix = ((sv >> (7 - x % 8)) & 1) != 0 ? fg : bg;
        else    pix = sv;
        dv = shadow[da];
        if (rop == 8'h00)      res = 0;
        else if (rop == 8'h0B) res = (~dv) & 8'hFF;
        else                   res = pix;
        expq.push_back((2 << 20) | (da << 8) | res);
        shadow[da] = res;
      end
    end
  endtask

  task automatic run(input string req, input int sb, db, sp, dp, w, h, md,
                     rop, fg, bg, input bit poke);
    int t;
    cur_req = req;
    wr(4'd0, sb); wr(4'd1, db); wr(4'd2, sp); wr(4'd3, dp);
    wr(4'd4, w);  wr(4'd5, h);  wr(4'd6, md); wr(4'd7, rop);
    wr(4'd8, fg); wr(4'd9, bg);
    model(sb, db, sp, dp, w, h, md, rop, fg, bg);
    busy_cycles = 0;
    done_seen = 0;
    wr(4'd10, 2);
    if (poke) begin
      repeat (9) @(negedge clk);
      wr(4'd10, 2);  // R9: start while busy has no effect
    end
    t = 0;
    while (busy && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R1", {req, " all pixels written"}, expq.size(), 0);
    chk(busy_cycles == 4 * (w + 1) * (h + 1), "R8", {req, " busy cycles"},
        busy_cycles, 4 * (w + 1) * (h + 1));
    chk(done_seen == 1, "R10", {req, " done pulses"}, done_seen, 1);
    expq.delete();
  endtask

  initial begin
    for (int i = 0; i < MSZ; i++) begin
      vmem[i] = 8'((i * 37 + 11) ^ (i >> 3));
      shadow[i] = int'(vmem[i]);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R9", "reset idle",
        {busy, done, mem_rd, mem_wr}, 0);

    run("R3", 16'h010, 16'h200, 16, 32, 3, 2, 8'h00, 8'h0D, 0, 0, 1'b0);
    run("R2", 16'h020, 16'h280, 8, 40, 6, 3, 8'h00, 8'h0D, 0, 0, 1'b0);
    run("R7", 16'h030, 16'h2F0, 4, 4, 0, 0, 8'h00, 8'h0B, 0, 0, 1'b0);
    run("R7", 16'h040, 16'h300, 8, 8, 2, 1, 8'h00, 8'h00, 0, 0, 1'b0);
    run("R7", 16'h050, 16'h310, 8, 8, 2, 1, 8'h00, 8'h55, 0, 0, 1'b0);
    run("R4", 16'h060, 16'h320, 4, 16, 11, 1, 8'h80, 8'h0D, 8'hA5, 8'h3C, 1'b0);
    run("R5", 16'h080, 16'h100, 0, 16, 9, 9, 8'h40, 8'h0D, 0, 0, 1'b0);
    run("R5", 16'h0C0, 16'h1B0, 0, 20, 15, 9, 8'hC0, 8'h0D, 8'h11, 8'hEE, 1'b0);
    run("R6", 16'h3F8, 16'h3FC, 16'h3F0, 16'h3E0, 5, 2, 8'h00, 8'h0D, 0, 0, 1'b0);
    run("R1", 16'h000, 16'h360, 8, 12, 7, 3, 8'h00, 8'h0B, 0, 0, 1'b1);

    // R9: mode bit 2 set blocks the start
    cur_req = "R9";
    wr(4'd6, 8'h04);
    busy_cycles = 0;
    events = 0;
    wr(4'd10, 2);
    repeat (20) @(negedge clk);
    chk(busy_cycles == 0 && events == 0, "R9", "host-source start ignored",
        busy_cycles + events, 0);
    // R9: control write without bit 1 does not start
    wr(4'd6, 8'h00);
    wr(4'd10, 8'h01);
    repeat (20) @(negedge clk);
    chk(busy_cycles == 0 && events == 0, "R9", "start bit clear ignored",
        busy_cycles + events, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule